// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block generates the horizontal sync, vertical sync, display-enable and blanking signals for a raster display. Horizontally it counts in word clocks and vertically in lines. It also presents the live column and line counters and a one-cycle line-start strobe, so that downstream fetch logic can follow the beam.

The timing comes from an eight-byte packed parameter block that a host writes one byte per cycle. The bytes go into a shadow copy first. The whole shadow is decoded and copied into the live timing only on the cycle where the last column of the last line wraps, so every frame runs on a single, consistent set of timing.

Top module: `crt_sync_gen`

## Requirements
- R1: A write with `prm_first` high stores the byte as byte 0 and points the next write at byte 1. Each plain write stores into the pointed byte and advances the pointer. Once byte 7 is stored, further plain writes change nothing. After reset the pointer is at byte 0.
- R2: Reset loads the block 10 4E 07 25 07 07 90 65 (byte 0 first) into both the shadow and the live timing, and clears column and line to 0. The first line therefore has 106 columns, 80 active, and a sync starting at column 87 that is 7 columns wide.
- R3: Active words per line are byte 1 plus 2. A line is laid out as: active words, then a front porch equal to byte 4 bits 5:0, then sync, then a back porch equal to bits 15:10 of the little-endian word in bytes 2–3, then 3 fixed clocks. The total is the sum of these parts.
- R4: Lines per frame are laid out as: active lines (bits 9:0 of the little-endian word in bytes 6–7), then a front porch equal to byte 5 bits 5:0, then vertical sync lasting bits 9:5 of word 2–3 lines, then a back porch equal to bits 15:10 of word 6–7.
- R5: When front porch, vertical sync and back porch are all zero, the frame holds exactly one blank line after the active lines.
- R6: An active line count field of 0 gives 1024 active lines.
- R7: `disp_en` is high exactly when the column is below the active width and the line is below the active count. `blank` is its inverse.
- R8: `hsync` is high for exactly the sync width (bits 4:0 of word 2–3) of columns, directly after the horizontal front porch. `vsync` follows the same rule on lines. A sync width of 0 gives no pulse. Neither sync is ever high together with `disp_en`.
- R9: Parameter writes do not affect the running frame. The shadow, including a partly written block, takes effect from column 0 of line 0 of the next frame.
- R10: The column advances by one every cycle and wraps to 0 after the last column. The line advances on each column wrap and wraps to 0 after the last line. `line_start` is high exactly when the column is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prm_we | input | 1 | Parameter byte write strobe |
| prm_first | input | 1 | With `prm_we`: this byte is byte 0 |
| prm_data | input | 8 | Parameter byte |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Inside the active area |
| blank | output | 1 | Outside the active area |
| line_start | output | 1 | High on column 0 of every line |
| col | output | 10 | Current column |
| row | output | 11 | Current line |

## Verification
The assertions check four things on every cycle: the column and line stepping, the exclusion of both syncs from the active area, the alignment of a vertical sync rise with a line start, and the rule that the live timing changes only at the frame wrap. Only the bench scenarios can show that the decoded widths are right, because each check compares a measured frame against totals computed from a known block. The same applies to the masking of the unused porch bits, the zero-blanking and 1024-line cases, pointer restart and overflow, and the old timing persisting after a write in mid-frame.

// File: rtl/crt_sync_pkg.sv
package crt_sync_pkg;

    localparam int PRM_BYTES = 8;
    localparam int PRM_BITS  = 8 * PRM_BYTES;
    localparam int PTR_W     = $clog2(PRM_BYTES + 1);
    // widest line: 257 + 31 + 63 + 63 + 3 ; tallest frame: 1024 + 31 + 63 + 63
    localparam int H_W       = 10;
    localparam int V_W       = 11;
    localparam int H_FIXED   = 3;
    localparam int W_EXTRA   = 2;

    // byte 0 in the least significant position
    localparam logic [PRM_BITS-1:0] PRM_DEFAULT =
        {8'h65, 8'h90, 8'h07, 8'h07, 8'h25, 8'h07, 8'h4E, 8'h10};

    typedef struct packed {
        logic [H_W-1:0] h_act;
        logic [H_W-1:0] h_sbeg;
        logic [H_W-1:0] h_send;
        logic [H_W-1:0] h_tot;
        logic [V_W-1:0] v_act;
        logic [V_W-1:0] v_sbeg;
        logic [V_W-1:0] v_send;
        logic [V_W-1:0] v_tot;
    } timing_t;

    function automatic timing_t decode_prm(input logic [PRM_BITS-1:0] blk);
        timing_t        t;
        logic [15:0]    w_sync;
        logic [15:0]    w_lines;
        logic [V_W-1:0] lines;
        logic [V_W-1:0] vblank;
        w_sync  = blk[31:16];
        w_lines = blk[63:48];
        t.h_act  = H_W'(blk[15:8]) + H_W'(W_EXTRA);
        t.h_sbeg = t.h_act + H_W'(blk[37:32]);
        t.h_send = t.h_sbeg + H_W'(w_sync[4:0]);
        t.h_tot  = t.h_send + H_W'(w_sync[15:10]) + H_W'(H_FIXED);
        lines    = (w_lines[9:0] == 10'd0) ? V_W'(1024) : V_W'(w_lines[9:0]);
        vblank   = V_W'(blk[45:40]) + V_W'(w_sync[9:5]) + V_W'(w_lines[15:10]);
        if (vblank == '0) begin
            vblank = V_W'(1);
        end
        t.v_act  = lines;
        t.v_sbeg = lines + V_W'(blk[45:40]);
        t.v_send = t.v_sbeg + V_W'(w_sync[9:5]);
        t.v_tot  = lines + vblank;
        return t;
    endfunction

endpackage

// File: rtl/crt_prm_shadow.sv
module crt_prm_shadow
    import crt_sync_pkg::*;
#(
    parameter logic [PRM_BITS-1:0] RESET_BLK = PRM_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                first,
    input  logic [7:0]          data,
    output logic [PRM_BITS-1:0] blk
);

    typedef struct packed {
        logic [PRM_BITS-1:0] bytes;
        logic [PTR_W-1:0]    ptr;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (first) begin
                st_d.bytes[7:0] = data;
                st_d.ptr        = PTR_W'(1);
            end else if (st_q.ptr < PTR_W'(PRM_BYTES)) begin
                st_d.bytes[8*st_q.ptr +: 8] = data;
                st_d.ptr                    = st_q.ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bytes <= RESET_BLK;
            st_q.ptr   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk = st_q.bytes;

endmodule

// File: rtl/crt_axis.sv
module crt_axis #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] act_len,
    input  logic [W-1:0] sync_beg,
    input  logic [W-1:0] sync_end,
    input  logic [W-1:0] total,
    output logic [W-1:0] pos,
    output logic         last,
    output logic         in_act,
    output logic         in_sync
);

    logic [W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step) begin
            pos_d = last ? '0 : pos_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign last    = (pos_q == total - W'(1));
    assign in_act  = (pos_q < act_len);
    assign in_sync = (pos_q >= sync_beg) && (pos_q < sync_end);
    assign pos     = pos_q;

endmodule

// File: rtl/crt_sync_gen.sv
module crt_sync_gen
    import crt_sync_pkg::*;
#(
    parameter logic [PRM_BITS-1:0] RESET_BLK = PRM_DEFAULT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prm_we,
    input  logic           prm_first,
    input  logic [7:0]     prm_data,
    output logic           hsync,
    output logic           vsync,
    output logic           disp_en,
    output logic           blank,
    output logic           line_start,
    output logic [H_W-1:0] col,
    output logic [V_W-1:0] row
);

    logic [PRM_BITS-1:0] shadow_blk;
    timing_t             act_d, act_q;
    logic                h_last, v_last, h_act, v_act, h_sync, v_sync;

    crt_prm_shadow #(.RESET_BLK(RESET_BLK)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prm_we),
        .first (prm_first),
        .data  (prm_data),
        .blk   (shadow_blk)
    );

    crt_axis #(.W(H_W)) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (1'b1),
        .act_len  (act_q.h_act),
        .sync_beg (act_q.h_sbeg),
        .sync_end (act_q.h_send),
        .total    (act_q.h_tot),
        .pos      (col),
        .last     (h_last),
        .in_act   (h_act),
        .in_sync  (h_sync)
    );

    crt_axis #(.W(V_W)) u_v (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (h_last),
        .act_len  (act_q.v_act),
        .sync_beg (act_q.v_sbeg),
        .sync_end (act_q.v_send),
        .total    (act_q.v_tot),
        .pos      (row),
        .last     (v_last),
        .in_act   (v_act),
        .in_sync  (v_sync)
    );

    // live timing swaps only when the frame wraps
    always_comb begin
        act_d = act_q;
        if (h_last && v_last) begin
            act_d = decode_prm(shadow_blk);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= decode_prm(RESET_BLK);
        end else begin
            act_q <= act_d;
        end
    end

    assign disp_en    = h_act && v_act;
    assign blank      = !disp_en;
    assign hsync      = h_sync;
    assign vsync      = v_sync;
    assign line_start = (col == '0);

endmodule

// File: rtl/crt_sync_chk.sv
module crt_sync_chk
    import crt_sync_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [H_W-1:0] col,
    input logic [V_W-1:0] row,
    input logic           hsync,
    input logic           vsync,
    input logic           disp_en,
    input logic           line_start,
    input timing_t        act_q
);

    // R10
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col != '0) |=> ((col == $past(col) + H_W'(1)) || (col == '0)));

    // R10
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row) |-> ((col == '0) && ((row == $past(row) + V_W'(1)) || (row == '0))));

    // R8
    hsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> !disp_en);

    // R8
    vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> !disp_en);

    // R4
    vsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> line_start);

    // R9
    frame_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> ((col == '0) && (row == '0)));

endmodule

bind crt_sync_gen crt_sync_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .col        (col),
    .row        (row),
    .hsync      (hsync),
    .vsync      (vsync),
    .disp_en    (disp_en),
    .line_start (line_start),
    .act_q      (act_q)
);

// File: tb/crt_sync_gen_test.sv
module crt_sync_gen_test;
    import crt_sync_pkg::*;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           prm_we = 1'b0;
    logic           prm_first = 1'b0;
    logic [7:0]     prm_data = 8'h00;
    logic           hsync, vsync, disp_en, blank, line_start;
    logic [H_W-1:0] col;
    logic [V_W-1:0] row;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    crt_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_first(prm_first),
        .prm_data(prm_data), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .blank(blank), .line_start(line_start), .col(col), .row(row)
    );

    localparam int NV   = 3;
    localparam int NONE = 9999;
    // blocks, byte 0 in the low bits
    localparam logic [63:0] VEC [NV] = '{
        {8'h04, 8'h04, 8'h42, 8'hC3, 8'h04, 8'h22, 8'h06, 8'h00},
        {8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'h08, 8'h00, 8'h01, 8'h01, 8'h00, 8'h41, 8'h00, 8'h00}
    };
    // h_act, hsync start, hsync width, h_total, v_act, vsync start, vsync width, v_total
    localparam int EXP [NV][8] = '{
        '{8, 11, 2, 17, 4, 6, 1, 8},
        '{2, NONE, 0, 5, 3, NONE, 0, 4},
        '{2, 3, 1, 7, 1024, 1025, 2, 1029}
    };
    localparam string REQ [8] = '{"R3", "R8", "R8", "R3", "R4", "R4", "R8", "R4"};

    int m [8];
    int bad_blank, bad_ls, n_ls;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit first, input logic [7:0] d);
        @(negedge clk);
        prm_we    = 1'b1;
        prm_first = first;
        prm_data  = d;
    endtask

    task automatic wr_end();
        @(negedge clk);
        prm_we    = 1'b0;
        prm_first = 1'b0;
    endtask

    task automatic load(input logic [63:0] blk);
        for (int i = 0; i < 8; i++) wr(i == 0, blk[8*i +: 8]);
    endtask

    task automatic sample();
        if (col + 1 > m[3]) m[3] = col + 1;
        if (row + 1 > m[7]) m[7] = row + 1;
        if (blank == disp_en) bad_blank++;
        if (line_start != (col == 0)) bad_ls++;
        if (line_start) n_ls++;
        if (row == 0) begin
            if (disp_en) m[0]++;
            if (hsync) begin
                if (m[1] == NONE) m[1] = col;
                m[2]++;
            end
        end
        if (col == 0) begin
            if (disp_en) m[4]++;
            if (vsync) begin
                if (m[5] == NONE) m[5] = row;
                m[6]++;
            end
        end
    endtask

    task automatic clear_m();
        m = '{0, NONE, 0, 0, 0, NONE, 0, 0};
        bad_blank = 0; bad_ls = 0; n_ls = 0;
    endtask

    task automatic wait_frame();
        while (row == 0) @(negedge clk);
        while (!(row == 0 && col == 0)) @(negedge clk);
    endtask

    task automatic measure_frame();
        clear_m();
        sample();
        forever begin
            @(negedge clk);
            if (row == 0 && col == 0) break;
            sample();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 col", int'(col), 0);
        chk("R2 row", int'(row), 0);
        chk("R7 disp_en", int'(disp_en), 1);
        chk("R8 hsync", int'(hsync), 0);
        chk("R10 line_start", int'(line_start), 1);
        rst_n = 1'b1;
        // R2 first line with reset timing
        clear_m();
        while (row == 0) begin
            sample();
            @(negedge clk);
        end
        chk("R2 line length", m[3], 106);
        chk("R2 active words", m[0], 80);
        chk("R2 hsync start", m[1], 87);
        chk("R2 hsync width", m[2], 7);
        // load block 0 mid-frame with one surplus byte
        load(VEC[0]);
        wr(1'b0, 8'hFF);
        wr_end();
        // R9 running frame keeps old timing
        while (col != 0) @(negedge clk);
        clear_m();
        sample();
        forever begin
            @(negedge clk);
            if (col == 0) break;
            sample();
        end
        chk("R9 line length after write", m[3], 106);
        for (int v = 0; v < NV; v++) begin
            wait_frame();
            measure_frame();
            for (int k = 0; k < 8; k++) chk(REQ[k], m[k], EXP[v][k]);
            chk("R7 blank inverse", bad_blank, 0);
            chk("R10 line_start at col 0", bad_ls, 0);
            chk("R10 line_start count", n_ls, EXP[v][7]);
            if (v == 0) begin
                chk("R1 surplus byte ignored", m[7], 8);
                // restart: partial garbage, then full block
                wr(1'b1, 8'hAA);
                wr(1'b0, 8'h55);
                wr(1'b0, 8'h55);
                load(VEC[1]);
                wr_end();
            end else if (v == 1) begin
                chk("R1 restart pointer", m[3], 5);
                chk("R5 single blank line", m[7] - m[4], 1);
                load(VEC[2]);
                wr_end();
            end else begin
                chk("R6 zero means 1024", m[4], 1024);
            end
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule